// File: doc/BRIEF.md
# Interrupt Vector Receive Unit

This unit sits beside a processor core and turns a bank of level-sensitive external interrupt lines into a single vectored interrupt. The unit looks for a low-to-high change on any line. When it sees one, it records that line's number in the first of three incoming-data words and raises a busy flag. It also asserts a level-5 pending request toward the core's trap logic and raises a hard-interrupt request. A high-to-low change on any line withdraws the request again.

Software reaches the unit through an alternate-space load/store port. The port carries a space identifier, an address, write data and a write enable, and it returns read data combinationally. One space reads and writes the busy flag. A second space reads the captured data words, and the word is picked by two address bits. A third space always reads zero. The unit does not sequence trap entry and it sends no interrupts out.

Top module: `ivec_rx_unit`

## Requirements
- R1: A line that changes from 0 to 1 between two clock edges sets the busy flag and `pendLevels[5]` at that edge. The busy flag reads as value 0x20 in the status space.
- R2: On a capture, data word 0 becomes 0x7C0 OR the vector number, which is 0x1f in bits [10:6] and the vector in bits [5:0]. Data words 1 and 2 become zero. A line that stays high does not capture again.
- R3: A line that changes from 1 to 0 clears the busy flag and `pendLevels[5]`. A capture in the same cycle takes precedence and leaves both set. Data words keep their values.
- R4: A read with space id 0x49 returns the status word, in which only bit 5 can be 1. A write with `asiWe` in space 0x49 keeps bit 5 of the write data and discards every other bit. A software write does not change `pendLevels`.
- R5: `hardReq` always equals the busy flag, so a software write of 0 to bit 5 lowers it.
- R6: A read with space id 0x7f returns data word `asiAddr[5:4]`, with other address bits ignored. Index 3 returns zero.
- R7: Reads in space 0x48 and in any unused space id return zero.
- R8: Writes in spaces 0x48 and 0x7f change neither the busy flag nor any data word.
- R9: When several lines rise in the same cycle, the lowest-numbered one is captured.
- R10: Reset clears the busy flag, `pendLevels`, `hardReq` and all data words. A line that is already high when reset ends does not count as a rise.
- R11: Precedence for the busy flag is capture, then line fall, then software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vecLines | input | NUM_VEC (48) | External interrupt lines, one per vector |
| asiId | input | 8 | Alternate space identifier |
| asiAddr | input | ADDR_W (16) | Alternate space address |
| asiWdata | input | DATA_W (64) | Write data |
| asiWe | input | 1 | Write enable |
| asiRdata | output | DATA_W (64) | Combinational read data |
| pendLevels | output | 16 | Pending interrupt levels; only bit 5 is used |
| hardReq | output | 1 | Hard interrupt request toward the core |

## Verification
The hardest situations to reach are the ones where three events land on one clock edge: one line falls while another rises, or a line event coincides with a software write to the status space. From the ports alone, the precedence between them cannot be seen any other way. The stimulus table keeps unrelated lines high for several rows. One step can then lower one line, raise another and drive a status write at the same time. A directed pass holds every line high through reset and checks that no capture follows.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam logic [7:0] ASI_DISPATCH = 8'h48;
  localparam logic [7:0] ASI_STATUS   = 8'h49;
  localparam logic [7:0] ASI_VECDATA  = 8'h7f;
  localparam int         BUSY_BIT     = 5;
  localparam int         PEND_LEVEL   = 5;
  localparam int         TAG_LSB      = 6;
  localparam logic [4:0] VEC_TAG      = 5'h1f;
  localparam int         IDX_W        = 8;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] vecIdx;
    logic             drop;
    logic             statusWrEn;
    logic             statusWrBit;
  } ivr_strobe_t;
endpackage

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
  import ivr_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] vecLines,
  input  logic [7:0]         asiId,
  input  logic               asiWe,
  input  logic [DATA_W-1:0]  asiWdata,
  output ivr_strobe_t        strb
);
  logic [NUM_VEC-1:0] prevLines;
  logic [NUM_VEC-1:0] riseVec;
  logic [NUM_VEC-1:0] fallVec;
  logic [IDX_W-1:0]   pickIdx;

  // Previous levels reset high so lines already up at reset do not count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= vecLines;
  end

  assign riseVec = vecLines & ~prevLines;
  assign fallVec = ~vecLines & prevLines;

  // Lowest-numbered rising line wins.
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (riseVec[i]) pickIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strb.capture     = |riseVec;
    strb.vecIdx      = pickIdx;
    strb.drop        = |fallVec;
    strb.statusWrEn  = asiWe && (asiId == ASI_STATUS);
    strb.statusWrBit = asiWdata[BUSY_BIT];
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    riseVec[0] |-> (strb.vecIdx == '0)); // R9
  AST_PICK_IS_RISING: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> riseVec[strb.vecIdx]); // R9
endmodule

// File: rtl/ivr_datapath.sv
module ivr_datapath
  import ivr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivr_strobe_t       strb,
  input  logic [7:0]        asiId,
  input  logic [ADDR_W-1:0] asiAddr,
  output logic [DATA_W-1:0] asiRdata,
  output logic [15:0]       pendLevels,
  output logic              hardReq
);
  localparam int NUM_WORDS = 3;

  logic              busyFlag;
  logic              pendFlag;
  logic [DATA_W-1:0] dataWord [NUM_WORDS];
  logic [DATA_W-1:0] capWord0;
  logic [1:0]        wordSel;

  always_comb begin
    capWord0 = '0;
    capWord0[TAG_LSB +: 5] = VEC_TAG;
    capWord0[TAG_LSB-1:0]  = strb.vecIdx[TAG_LSB-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyFlag <= 1'b0;
      pendFlag <= 1'b0;
    end else begin
      if (strb.capture) begin
        busyFlag <= 1'b1;
        pendFlag <= 1'b1;
      end else if (strb.drop) begin
        busyFlag <= 1'b0;
        pendFlag <= 1'b0;
      end else if (strb.statusWrEn) begin
        busyFlag <= strb.statusWrBit;
      end
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             dataWord[w] <= '0;
      else if (strb.capture) dataWord[w] <= (w == 0) ? capWord0 : '0;
    end
  end

  assign wordSel = asiAddr[5:4];

  always_comb begin
    asiRdata = '0;
    case (asiId)
      ASI_STATUS:  asiRdata[BUSY_BIT] = busyFlag;
      ASI_VECDATA: if (wordSel != 2'd3) asiRdata = dataWord[wordSel];
      default:     asiRdata = '0;
    endcase
  end

  always_comb begin
    pendLevels = '0;
    pendLevels[PEND_LEVEL] = pendFlag;
  end
  assign hardReq = busyFlag;

  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (busyFlag && pendFlag)); // R1
  AST_WORD0_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (dataWord[0][TAG_LSB +: 5] == VEC_TAG)); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (dataWord[1] == '0 && dataWord[2] == '0)); // R2
  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drop && !strb.capture) |=> (!busyFlag && !pendFlag)); // R3
  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusWrEn && !strb.capture && !strb.drop)
      |=> (busyFlag == $past(strb.statusWrBit) && $stable(pendFlag))); // R4
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(dataWord[0]) && $stable(dataWord[1]))); // R8
endmodule

// File: rtl/ivec_rx_unit.sv
module ivec_rx_unit
  import ivr_pkg::*;
#(
  parameter int NUM_VEC = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] vecLines,
  input  logic [7:0]         asiId,
  input  logic [ADDR_W-1:0]  asiAddr,
  input  logic [DATA_W-1:0]  asiWdata,
  input  logic               asiWe,
  output logic [DATA_W-1:0]  asiRdata,
  output logic [15:0]        pendLevels,
  output logic               hardReq
);
  ivr_strobe_t strb;

  ivr_ctrl #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .vecLines(vecLines), .asiId(asiId),
    .asiWe(asiWe), .asiWdata(asiWdata), .strb(strb)
  );

  ivr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .asiId(asiId), .asiAddr(asiAddr),
    .asiRdata(asiRdata), .pendLevels(pendLevels), .hardReq(hardReq)
  );

  AST_HARD_FOLLOWS_PEND_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendLevels[PEND_LEVEL]) |-> hardReq); // R5
endmodule

// File: tb/test_ivec_rx_unit.sv
`timescale 1ns/100ps
module test_ivec_rx_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] vecLines = '0;
  logic [7:0]  asiId = '0;
  logic [15:0] asiAddr = '0;
  logic [63:0] asiWdata = '0;
  logic        asiWe = 1'b0;
  logic [63:0] asiRdata;
  logic [15:0] pendLevels;
  logic        hardReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  ivec_rx_unit i_ivec_rx_unit (
    .clk(clk), .rstN(rstN), .vecLines(vecLines), .asiId(asiId),
    .asiAddr(asiAddr), .asiWdata(asiWdata), .asiWe(asiWe),
    .asiRdata(asiRdata), .pendLevels(pendLevels), .hardReq(hardReq)
  );

  typedef struct packed {
    logic [47:0] lines;
    logic        we;
    logic [7:0]  id;
    logic [63:0] wd;
    logic        st;
    logic        pd;
    logic [10:0] w0;
    logic [39:0] tag;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t TBL [NROWS] = '{
    '{48'h0,               1'b0, 8'h00, 64'h0,                   1'b0, 1'b0, 11'h000, "R10  "},
    '{48'h8,               1'b0, 8'h00, 64'h0,                   1'b1, 1'b1, 11'h7C3, "R1 R2"},
    '{48'h8,               1'b0, 8'h00, 64'h0,                   1'b1, 1'b1, 11'h7C3, "R2   "},
    '{48'h0,               1'b0, 8'h00, 64'h0,                   1'b0, 1'b0, 11'h7C3, "R3   "},
    '{48'h220,             1'b0, 8'h00, 64'h0,                   1'b1, 1'b1, 11'h7C5, "R9   "},
    '{48'h200,             1'b0, 8'h00, 64'h0,                   1'b0, 1'b0, 11'h7C5, "R3   "},
    '{48'h8000_0000_0200,  1'b0, 8'h00, 64'h0,                   1'b1, 1'b1, 11'h7EF, "R2   "},
    '{48'h8000_0000_0200,  1'b1, 8'h49, 64'h0,                   1'b0, 1'b1, 11'h7EF, "R5   "},
    '{48'h8000_0000_0200,  1'b1, 8'h49, 64'hFFFF_FFFF_FFFF_FFDF, 1'b0, 1'b1, 11'h7EF, "R4   "},
    '{48'h8000_0000_0200,  1'b1, 8'h49, 64'h20,                  1'b1, 1'b1, 11'h7EF, "R4   "},
    '{48'h8000_0000_0200,  1'b1, 8'h48, 64'h0,                   1'b1, 1'b1, 11'h7EF, "R8   "},
    '{48'h8000_0000_0200,  1'b1, 8'h7f, 64'h0,                   1'b1, 1'b1, 11'h7EF, "R8   "},
    '{48'h201,             1'b0, 8'h00, 64'h0,                   1'b1, 1'b1, 11'h7C0, "R3   "},
    '{48'h1,               1'b1, 8'h49, 64'h20,                  1'b0, 1'b0, 11'h7C0, "R11  "},
    '{48'h3,               1'b1, 8'h49, 64'h0,                   1'b1, 1'b1, 11'h7C1, "R11  "}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] id, input logic [15:0] addr, output logic [63:0] v);
    asiWe = 1'b0;
    asiId = id;
    asiAddr = addr;
    #0.2;
    v = asiRdata;
  endtask

  task automatic step(input logic [47:0] l, input logic we, input logic [7:0] id,
                      input logic [63:0] wd);
    @(negedge clk);
    vecLines = l; asiWe = we; asiId = id; asiWdata = wd; asiAddr = '0;
    @(posedge clk);
    #1;
    asiWe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    // R10: reset state, with all lines held high through reset
    vecLines = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 hardReq in reset", {63'b0, hardReq}, 64'h0);
    check("R10 pendLevels in reset", {48'b0, pendLevels}, 64'h0);
    rd(8'h49, 16'h0, v); check("R10 status in reset", v, 64'h0);
    rd(8'h7f, 16'h0, v); check("R10 word0 in reset", v, 64'h0);
    @(negedge clk); rstN = 1'b1;
    step('1, 1'b0, 8'h00, 64'h0);
    check("R10 no rise from held lines", {63'b0, hardReq}, 64'h0);
    check("R10 no pending from held lines", {48'b0, pendLevels}, 64'h0);

    // Table walk
    for (int r = 0; r < NROWS; r++) begin
      step(TBL[r].lines, TBL[r].we, TBL[r].id, TBL[r].wd);
      check($sformatf("%s row %0d hardReq", TBL[r].tag, r), {63'b0, hardReq}, {63'b0, TBL[r].st});
      check($sformatf("%s row %0d pendLevels", TBL[r].tag, r), {48'b0, pendLevels},
            TBL[r].pd ? 64'h20 : 64'h0);
      rd(8'h49, 16'h0, v);
      check($sformatf("%s row %0d status", TBL[r].tag, r), v, TBL[r].st ? 64'h20 : 64'h0);
      rd(8'h7f, 16'h0, v);
      check($sformatf("%s row %0d word0", TBL[r].tag, r), v, {53'b0, TBL[r].w0});
    end

    // R6: word selection by address bits [5:4]
    rd(8'h7f, 16'h004F, v); check("R6 word0 with other address bits", v, 64'h7C1);
    rd(8'h7f, 16'h0010, v); check("R6 word1 zero", v, 64'h0);
    rd(8'h7f, 16'h0020, v); check("R6 word2 zero", v, 64'h0);
    rd(8'h7f, 16'h0030, v); check("R6 index 3 zero", v, 64'h0);
    // R7: dispatch space and unused space read zero
    rd(8'h48, 16'h0, v); check("R7 space 0x48 reads zero", v, 64'h0);
    rd(8'h50, 16'h0, v); check("R7 unused space reads zero", v, 64'h0);
    // R2: rising line 40 after lines low
    step(48'h0, 1'b0, 8'h00, 64'h0);
    step(48'h0100_0000_0000, 1'b0, 8'h00, 64'h0);
    rd(8'h7f, 16'h0, v); check("R2 capture of vector 40", v, 64'h7E8);
    // R5: software clear drops hardReq
    step(48'h0100_0000_0000, 1'b1, 8'h49, 64'h0);
    check("R5 hardReq after software clear", {63'b0, hardReq}, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule